// File: doc/BRIEF.md
# Write-Once Thermal Shutdown Guard

This block watches five temperature channels (one on-die sensor, channel 0, and four remote sensors, channels 1 to 4) and drives an active-low system shutdown line. Each channel has an 8-bit two's-complement critical limit. Software may program each limit exactly once after reset. That same write freezes the limit and arms the channel for the shutdown path. A channel that was never written can never cause a shutdown, whatever its temperature.

Separately, each remote channel has a high limit supplied from outside the block. Crossing it always records a high-limit event. Crossing it also pulls the shutdown line when the channel's link bit is set in the configuration register. Sticky status registers record critical and high events, and an interrupt status register summarises them. An alert output reports pending status unless a global mask bit or a per-source mask blocks it. Channel 4 can be switched to a voltage-input mode, in which it takes part in no comparison at all.

Top module: `thermal_trip_guard`

## Requirements
- R1: After reset every limit reads 0x64 (+100 degrees), the lock flags (address 6, bit k for channel k) read 0, configuration (address 5) and all status registers read 0, `shdn_n` is 1 and `alert` is 0.
- R2: The first write to a limit address (0 to 4, channel k at address k) stores the data and sets that channel's lock flag. The flag stays set until reset.
- R3: Any write to a locked limit address is ignored: the stored value does not change and no error is signalled.
- R4: A channel whose lock flag is 0 never sets its critical status bit and never pulls `shdn_n` low, even when its temperature exceeds the stored limit.
- R5: When an armed channel's temperature is strictly greater than its limit (signed compare; equal does not trip), then after the next clock edge `shdn_n` is 0, critical status bit k (address 7) is 1 and interrupt status bit 0 (address 9) is 1.
- R6: `shdn_n` is registered and returns to 1 one clock edge after no armed critical exceedance and no linked high exceedance remains. Status bits stay set.
- R7: A remote channel j (1 to 4) above its high limit sets high status bit j-1 (address 8) and interrupt status bit 1. It pulls `shdn_n` low only when configuration bit j is 1.
- R8: `alert` is 1 exactly when configuration bit 7 is 0 and either the critical status is nonzero with alert-mask bit 0 (address 10) clear, or the high status is nonzero with alert-mask bit 1 clear.
- R9: Writing ones to a status address (7, 8 or 9) clears those bits. A condition present in the same cycle sets its bit anyway (set wins).
- R10: While `ext4_volt_mode` is 1, channel 4 sets no critical or high status and cannot pull `shdn_n` low, even with configuration bit 4 set.
- R11: Limits and temperatures are two's complement: bit 7 is the sign and bits 6 to 0 weigh 64 down to 1 degree, so a limit of 0xF6 (-10) is exceeded by 0xFB (-5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from address) |
| temp_in | input | 40 | Measured temperatures, channel k at bits 8k+7:8k |
| high_lim_in | input | 32 | High limits of channels 1 to 4, channel j at bits 8(j-1)+7:8(j-1) |
| ext4_volt_mode | input | 1 | Channel 4 is a voltage input and is not compared |
| shdn_n | output | 1 | Active-low system shutdown |
| alert | output | 1 | Alert request |

## Verification
The sharpest corner is an unwritten channel running far above its default limit. A design that arms on reset, or that compares every channel, would trip shutdown there. A second write to a locked limit must read back the first value; a design that lets the lock slip would show the new value. Equal-to-limit readings and negative limits test the signed, strict compare, which a design with an unsigned or inclusive compare would get wrong. A clear written while the condition persists must leave the bit set. Voltage mode with the link bit set must keep channel 4 silent, where a design that only gates the link bit would still record status.

// File: rtl/tsg_pkg.sv
// Package: register map and shared constants of the thermal shutdown guard.
// Assumes a 4-bit register address space.
package tsg_pkg;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] A_CFG     = 4'd5;
    localparam logic [ADDR_W-1:0] A_LOCK    = 4'd6;
    localparam logic [ADDR_W-1:0] A_CRIT_ST = 4'd7;
    localparam logic [ADDR_W-1:0] A_HIGH_ST = 4'd8;
    localparam logic [ADDR_W-1:0] A_INT_ST  = 4'd9;
    localparam logic [ADDR_W-1:0] A_AMASK   = 4'd10;
    localparam int CFG_MASK_BIT = 7;
endpackage

// File: rtl/tsg_limit_bank.sv
// Write-once limit bank: one register per channel, loaded by the first
// write to its address, frozen afterwards until reset. The lock flag of a
// channel doubles as its arm flag. Assumes channel k sits at address k.
module tsg_limit_bank #(
    parameter int N_CH    = 5,
    parameter int TW      = 8,
    parameter int AW      = 4,
    parameter logic [TW-1:0] RST_VAL = 8'h64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [TW-1:0]     wdata_i,
    output logic [N_CH*TW-1:0] lim_o,
    output logic [N_CH-1:0]   lock_o
);
    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        logic [TW-1:0] lim_q;
        logic          lock_q;
        logic          hit;
        assign hit = we_i && (addr_i == AW'(k));
        // Purpose: load once, then hold value and lock until reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lim_q  <= RST_VAL;
                lock_q <= 1'b0;
            end else if (hit && !lock_q) begin
                lim_q  <= wdata_i;
                lock_q <= 1'b1;
            end
        end
        assign lim_o[k*TW +: TW] = lim_q;
        assign lock_o[k]         = lock_q;
    end
endmodule

// File: rtl/tsg_compare.sv
// Comparator array: signed, strict greater-than of each temperature
// against its critical limit (gated by arm) and of each remote channel
// against its high limit. The last remote channel is skipped in voltage mode.
// Purely combinational; assumes channel 0 is the on-die sensor.
module tsg_compare #(
    parameter int N_EXT = 4,
    parameter int TW    = 8,
    localparam int N_CH = N_EXT + 1
) (
    input  logic [N_CH*TW-1:0]  temp_i,
    input  logic [N_CH*TW-1:0]  lim_i,
    input  logic [N_EXT*TW-1:0] high_i,
    input  logic [N_CH-1:0]     arm_i,
    input  logic                volt_i,
    output logic [N_CH-1:0]     crit_hit_o,
    output logic [N_EXT-1:0]    high_hit_o
);
    logic [N_CH-1:0] active;

    for (genvar k = 0; k < N_CH; k++) begin : g_crit
        if (k == N_CH - 1) begin : g_last
            assign active[k] = !volt_i;
        end else begin : g_norm
            assign active[k] = 1'b1;
        end
        assign crit_hit_o[k] = active[k] && arm_i[k] &&
            ($signed(temp_i[k*TW +: TW]) > $signed(lim_i[k*TW +: TW]));
    end

    for (genvar j = 0; j < N_EXT; j++) begin : g_high
        assign high_hit_o[j] = active[j+1] &&
            ($signed(temp_i[(j+1)*TW +: TW]) > $signed(high_i[j*TW +: TW]));
    end
endmodule

// File: rtl/tsg_status.sv
// Sticky status register: bits set by events, cleared by write-one-to-clear.
// A set in the same cycle as its clear wins.
module tsg_status #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] clr_eff;
    assign clr_eff = clr_we_i ? clr_i : '0;
    // Purpose: accumulate events, drop acknowledged bits.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= (q_o & ~clr_eff) | set_i;
    end
endmodule

// File: rtl/thermal_trip_guard.sv
// Top: write-once critical limits, configuration, sticky status, registered
// active-low shutdown and masked alert. Assumes N_EXT+1 <= TW and TW >= 8
// (the global alert mask sits at bit 7 of the configuration register).
module thermal_trip_guard
    import tsg_pkg::*;
#(
    parameter int N_EXT = 4,
    parameter int TW    = 8,
    parameter logic [TW-1:0] LIM_RST = 8'h64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [TW-1:0]           reg_wdata,
    output logic [TW-1:0]           reg_rdata,
    input  logic [(N_EXT+1)*TW-1:0] temp_in,
    input  logic [N_EXT*TW-1:0]     high_lim_in,
    input  logic                    ext4_volt_mode,
    output logic                    shdn_n,
    output logic                    alert
);
    localparam int N_CH = N_EXT + 1;

    logic [N_CH*TW-1:0] lim_w;
    logic [N_CH-1:0]    lock_w;
    logic [N_CH-1:0]    crit_hit;
    logic [N_EXT-1:0]   high_hit;
    logic [N_CH-1:0]    crit_q;
    logic [N_EXT-1:0]   high_q;
    logic [1:0]         int_q;
    logic               cfg_mask_q;
    logic [N_EXT-1:0]   cfg_link_q;
    logic [1:0]         amask_q;
    logic               shdn_n_q;

    tsg_limit_bank #(.N_CH(N_CH), .TW(TW), .AW(ADDR_W), .RST_VAL(LIM_RST)) u_bank (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .lim_o(lim_w), .lock_o(lock_w)
    );

    tsg_compare #(.N_EXT(N_EXT), .TW(TW)) u_cmp (
        .temp_i(temp_in), .lim_i(lim_w), .high_i(high_lim_in), .arm_i(lock_w),
        .volt_i(ext4_volt_mode), .crit_hit_o(crit_hit), .high_hit_o(high_hit)
    );

    tsg_status #(.W(N_CH)) u_crit_st (
        .clk(clk), .rst_n(rst_n), .set_i(crit_hit),
        .clr_we_i(reg_we && reg_addr == A_CRIT_ST), .clr_i(reg_wdata[N_CH-1:0]),
        .q_o(crit_q)
    );

    tsg_status #(.W(N_EXT)) u_high_st (
        .clk(clk), .rst_n(rst_n), .set_i(high_hit),
        .clr_we_i(reg_we && reg_addr == A_HIGH_ST), .clr_i(reg_wdata[N_EXT-1:0]),
        .q_o(high_q)
    );

    tsg_status #(.W(2)) u_int_st (
        .clk(clk), .rst_n(rst_n), .set_i({|high_hit, |crit_hit}),
        .clr_we_i(reg_we && reg_addr == A_INT_ST), .clr_i(reg_wdata[1:0]),
        .q_o(int_q)
    );

    // Purpose: software-writable configuration and alert source masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_mask_q <= 1'b0;
            cfg_link_q <= '0;
            amask_q    <= '0;
        end else if (reg_we) begin
            if (reg_addr == A_CFG) begin
                cfg_mask_q <= reg_wdata[CFG_MASK_BIT];
                cfg_link_q <= reg_wdata[N_EXT:1];
            end
            if (reg_addr == A_AMASK) amask_q <= reg_wdata[1:0];
        end
    end

    // Purpose: register the shutdown request from all live trip conditions.
    always_ff @(posedge clk) begin
        if (!rst_n) shdn_n_q <= 1'b1;
        else        shdn_n_q <= !((|crit_hit) || (|(high_hit & cfg_link_q)));
    end

    assign shdn_n = shdn_n_q;
    assign alert  = !cfg_mask_q &&
                    (((|crit_q) && !amask_q[0]) || ((|high_q) && !amask_q[1]));

    // Purpose: combinational read mux over the register map.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr < ADDR_W'(N_CH)) begin
            for (int k = 0; k < N_CH; k++)
                if (reg_addr == ADDR_W'(k)) reg_rdata = lim_w[k*TW +: TW];
        end else begin
            case (reg_addr)
                A_CFG: begin
                    reg_rdata[CFG_MASK_BIT] = cfg_mask_q;
                    reg_rdata[N_EXT:1]      = cfg_link_q;
                end
                A_LOCK:    reg_rdata[N_CH-1:0]  = lock_w;
                A_CRIT_ST: reg_rdata[N_CH-1:0]  = crit_q;
                A_HIGH_ST: reg_rdata[N_EXT-1:0] = high_q;
                A_INT_ST:  reg_rdata[1:0]       = int_q;
                A_AMASK:   reg_rdata[1:0]       = amask_q;
                default:   reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tsg_checker.sv
// Checker: temporal properties of the thermal shutdown guard, bound to the
// top module. Observes lock, limit and status state plus the outputs.
module tsg_checker #(
    parameter int N_CH = 5,
    parameter int N_EXT = 4,
    parameter int TW = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_CH-1:0]     lock,
    input logic [N_CH*TW-1:0]  lim,
    input logic [N_CH-1:0]     crit,
    input logic [N_EXT-1:0]    high,
    input logic                volt,
    input logic                shdn_n,
    input logic                alert
);
    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) lock[k] |=> lock[k]); // R2
        AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) lock[k] |=> $stable(lim[k*TW +: TW])); // R3
        AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !lock[k] |-> !crit[k]); // R4
    end
    AST_SHDN_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) !shdn_n |-> ((|crit) || (|high))); // R5
    AST_ALERT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) alert |-> ((|crit) || (|high))); // R8
    AST_VOLT_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (volt && !crit[N_CH-1]) |=> !crit[N_CH-1]); // R10
endmodule

bind thermal_trip_guard tsg_checker #(.N_CH(N_EXT+1), .N_EXT(N_EXT), .TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .lock(lock_w), .lim(lim_w), .crit(crit_q),
    .high(high_q), .volt(ext4_volt_mode), .shdn_n(shdn_n), .alert(alert)
);

// File: tb/thermal_trip_guard_bench.sv
module thermal_trip_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [39:0] temp_in;
    logic [31:0] high_lim_in = {4{8'h30}};
    logic        ext4_volt_mode = 1'b0;
    logic        shdn_n, alert;
    int checks = 0, errors = 0;

    localparam logic [39:0] SAFE = {8'h00, 8'h00, 8'h00, 8'hEC, 8'h00};
    // {temps[39:0], shdn_n, crit[4:0], high[3:0]}
    localparam logic [49:0] VEC [8] = '{
        {SAFE,                                  1'b1, 5'b00000, 4'b0000},
        {8'h00, 8'h00, 8'h00, 8'hEC, 8'h51,     1'b0, 5'b00001, 4'b0000},
        {8'h00, 8'h00, 8'h00, 8'hEC, 8'h50,     1'b1, 5'b00000, 4'b0000},
        {8'h00, 8'h00, 8'h00, 8'hFB, 8'h00,     1'b0, 5'b00010, 4'b0000},
        {8'h00, 8'h7F, 8'h00, 8'hEC, 8'h00,     1'b1, 5'b00000, 4'b0100},
        {8'h00, 8'h00, 8'h31, 8'hEC, 8'h00,     1'b0, 5'b00000, 4'b0010},
        {8'h7F, 8'h00, 8'h00, 8'hEC, 8'h00,     1'b1, 5'b00000, 4'b1000},
        {8'h00, 8'h00, 8'h00, 8'h40, 8'h00,     1'b0, 5'b00010, 4'b0001}
    };

    thermal_trip_guard u_thermal_trip_guard (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .temp_in(temp_in),
        .high_lim_in(high_lim_in), .ext4_volt_mode(ext4_volt_mode),
        .shdn_n(shdn_n), .alert(alert)
    );

    always #2 clk = ~clk;

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_reg(input string req, input logic [3:0] a, input logic [7:0] exp);
        reg_addr = a; #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic clear_all();
        temp_in = SAFE;
        tick();
        wr(4'd7, 8'h1F); wr(4'd8, 8'h0F); wr(4'd9, 8'h03);
    endtask

    initial begin
        temp_in = SAFE;
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        for (int k = 0; k < 5; k++) chk_reg("R1 limit", 4'(k), 8'h64);
        chk_reg("R1 lock", 4'd6, 8'h00);
        chk_reg("R1 cfg", 4'd5, 8'h00);
        chk_reg("R1 crit", 4'd7, 8'h00);
        chk("R1 shdn_n", {7'd0, shdn_n}, 8'h01);
        chk("R1 alert", {7'd0, alert}, 8'h00);
        // R4 unarmed channel above default limit
        temp_in = {8'h00, 8'h00, 8'h00, 8'hEC, 8'h70};
        tick(); tick();
        chk("R4 shdn_n unarmed", {7'd0, shdn_n}, 8'h01);
        chk_reg("R4 crit unarmed", 4'd7, 8'h00);
        temp_in = SAFE;
        // R2 arm three channels
        wr(4'd0, 8'h50); wr(4'd1, 8'hF6); wr(4'd2, 8'h64);
        chk_reg("R2 lock flags", 4'd6, 8'h07);
        chk_reg("R2 limit ch1", 4'd1, 8'hF6);
        // R3 second write ignored
        wr(4'd0, 8'h10);
        chk_reg("R3 locked ch0", 4'd0, 8'h50);
        wr(4'd5, 8'h04); // R7 link remote channel 2
        chk_reg("R7 cfg", 4'd5, 8'h04);
        // Table walk (R5, R7, R11, R4)
        for (int i = 0; i < 8; i++) begin
            temp_in = VEC[i][49:10];
            tick();
            chk("R5 vec shdn_n", {7'd0, shdn_n}, {7'd0, VEC[i][9]});
            chk_reg("R5 vec crit", 4'd7, {3'd0, VEC[i][8:4]});
            chk_reg("R7 vec high", 4'd8, {4'd0, VEC[i][3:0]});
            chk_reg("R5 vec int", 4'd9, {6'd0, |VEC[i][3:0], |VEC[i][8:4]});
            chk("R8 vec alert", {7'd0, alert}, {7'd0, |VEC[i][8:0] & ~&VEC[i][9:9] | |VEC[i][8:0]});
            clear_all();
        end
        // R6 release while status sticky
        temp_in = {8'h00, 8'h00, 8'h00, 8'hEC, 8'h60};
        tick();
        chk("R6 tripped", {7'd0, shdn_n}, 8'h00);
        temp_in = SAFE;
        tick();
        chk("R6 released", {7'd0, shdn_n}, 8'h01);
        chk_reg("R6 status kept", 4'd7, 8'h01);
        // R8 masks
        chk("R8 alert on", {7'd0, alert}, 8'h01);
        wr(4'd10, 8'h01);
        chk("R8 source mask", {7'd0, alert}, 8'h00);
        wr(4'd10, 8'h00);
        wr(4'd5, 8'h84);
        chk("R8 global mask", {7'd0, alert}, 8'h00);
        wr(4'd5, 8'h04);
        clear_all();
        // R9 set wins over clear
        temp_in = {8'h00, 8'h00, 8'h00, 8'hEC, 8'h60};
        tick();
        wr(4'd7, 8'h01);
        chk_reg("R9 set wins", 4'd7, 8'h01);
        temp_in = SAFE; tick();
        wr(4'd7, 8'h01);
        chk_reg("R9 cleared", 4'd7, 8'h00);
        clear_all();
        // R10 voltage mode on channel 4
        wr(4'd4, 8'h10); wr(4'd5, 8'h14);
        ext4_volt_mode = 1'b1;
        temp_in = {8'h7F, 8'h00, 8'h00, 8'hEC, 8'h00};
        tick(); tick();
        chk("R10 no shdn", {7'd0, shdn_n}, 8'h01);
        chk_reg("R10 no crit", 4'd7, 8'h00);
        chk_reg("R10 no high", 4'd8, 8'h00);
        ext4_volt_mode = 1'b0;
        tick();
        chk("R10 normal shdn", {7'd0, shdn_n}, 8'h00);
        chk_reg("R10 normal crit", 4'd7, 8'h10);
        // R11 negative limit vs equal negative temp
        clear_all();
        temp_in = {8'h00, 8'h00, 8'h00, 8'hF6, 8'h00};
        tick();
        chk_reg("R11 equal negative", 4'd7, 8'h00);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule